// File: doc/BRIEF.md
# JTAG-to-DMI Debug Transport with Sticky Errors

This block sits behind a JTAG TAP controller. It turns scans of a debug-access data register into read and write requests towards a debug module. A debugger shifts in an address, a 32-bit data word and an operation code. On the update strobe the block starts a request on a valid/ready channel, and it takes the reply on a second valid/ready channel. On the next scan, the capture phase returns the last address, the last good read data and a status code that follows the reply that actually came back. A busy or failed reply is therefore reported as such, and is not covered by a fixed success code.

Any error puts the transport in a sticky state. While that state is set, new scanned operations are dropped. It stays set until the debugger writes the clear bit of a separate 32-bit control/status register. The first failing request (its op, address and data) is held on dedicated output ports so that it can be examined afterwards. A later error never replaces it, and never replaces the sticky code. The Test-Logic-Reset strobe brings every register of the block back to its initial value.

Top module: `dtm_bridge`

## Requirements
- R1: The debug-access scan register is ADDR_W+34 bits wide and is shifted least significant bit first. Bits [1:0] hold the op, bits [33:2] hold the data and the upper ADDR_W bits hold the address. Input op 1 is a read, op 2 is a write, and ops 0 and 3 start no request.
- R2: A read or write leaves on `req_valid` together with `req_write`, `req_addr` and `req_data`. These stay stable until `req_ready` is seen. At most one request is outstanding, and `rsp_ready` is high only while a reply is awaited.
- R3: The captured op field reports 0 for success, 2 for failure and 3 for busy, and never 1. It shows the sticky code when one is set, busy while a request is still outstanding, and success otherwise. A reply code of 0 is success, 3 is busy and any other value is failure.
- R4: The captured data field changes only when a read receives a success reply. A busy or failed reply leaves the previous read data in place.
- R5: A busy or failed reply sets the sticky code only if no sticky code is pending. A pending code is never overwritten.
- R6: While a sticky code is pending, scanned operations are ignored and no request is issued.
- R7: An update that arrives while a request is outstanding is dropped. If no sticky code is pending, it sets the sticky code to busy.
- R8: The first failing operation is latched on `err_op`/`err_addr`/`err_data`. For a failed reply this is the issued request. For a dropped update it is the dropped operation. Later failures leave the latch unchanged.
- R9: The control/status register is 32 bits wide. On capture it reports version 1 in bits [3:0], ADDR_W in bits [9:4] and the sticky code in bits [11:10]. An update with bit 16 set clears the sticky code.
- R10: A cycle with `tap_reset` high clears the scan register, the sticky code, the outstanding request, the read data, the address and the failure latch.
- R11: After `rst_n` the block has no request outstanding, no sticky code and an all-zero failure latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_reset | input | 1 | TAP is in Test-Logic-Reset |
| sel_dmi | input | 1 | Debug-access register selected by the instruction |
| sel_ctl | input | 1 | Control/status register selected by the instruction |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted |
| req_write | output | 1 | Request is a write |
| req_addr | output | ADDR_W | Request address |
| req_data | output | 32 | Request write data |
| rsp_valid | input | 1 | Reply valid |
| rsp_ready | output | 1 | Reply awaited |
| rsp_data | input | 32 | Reply read data |
| rsp_code | input | 2 | Reply code: 0 ok, 3 busy, other failed |
| err_op | output | 2 | Latched op of the first failure |
| err_addr | output | ADDR_W | Latched address of the first failure |
| err_data | output | 32 | Latched data of the first failure |

## Verification
The bench builds the block with ADDR_W = 6, so the scan register is 40 bits wide and the address field is the same width as the captured abits value. This also lets an all-ones address (0x3F) sit in the failure latch as a boundary case. A configurable reply latency of up to 120 cycles is longer than a full 40-bit scan. That puts a second update inside an outstanding request, which is needed to exercise dropping (R7) and to check that a later failed reply leaves the busy code in place (R5).

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CTL_W  = 32;
  localparam int unsigned CLR_BIT = 16;
  localparam logic [3:0]  CTL_VERSION = 4'd1;

  // scanned op codes
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;

  // status / reply codes
  localparam logic [1:0] ST_OK   = 2'd0;
  localparam logic [1:0] ST_FAIL = 2'd2;
  localparam logic [1:0] ST_BUSY = 2'd3;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_RSP  = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic [1:0]        op;
    logic [DATA_W-1:0] data;
  } fail_info_t;
endpackage

// File: rtl/dtm_scan.sv
module dtm_scan
  import dtm_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned SR_W  = ADDR_W + DATA_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tap_reset,
  input  logic            sel_dmi,
  input  logic            sel_ctl,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            tdi,
  input  logic [SR_W-1:0] cap_dmi,
  input  logic [CTL_W-1:0] cap_ctl,
  output logic [SR_W-1:0] sr,
  output logic            tdo
);
  logic [SR_W-1:0] sr_q, sr_d;
  logic            sr_en;

  assign sr_en = tap_reset | ((capture_dr | shift_dr) & (sel_dmi | sel_ctl));

  always_comb begin
    sr_d = sr_q;
    if (tap_reset) begin
      sr_d = '0;
    end else if (capture_dr) begin
      if (sel_dmi)      sr_d = cap_dmi;
      else if (sel_ctl) sr_d = SR_W'(cap_ctl);
    end else if (shift_dr) begin
      if (sel_dmi)      sr_d = {tdi, sr_q[SR_W-1:1]};
      else if (sel_ctl) sr_d[CTL_W-1:0] = {tdi, sr_q[CTL_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign sr  = sr_q;
  assign tdo = sr_q[0];
endmodule

// File: rtl/dtm_core.sv
module dtm_core
  import dtm_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned SR_W  = ADDR_W + DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_reset,
  input  logic              upd_dmi,
  input  logic              upd_ctl,
  input  logic [SR_W-1:0]   sr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [1:0]        rsp_code,
  output logic [1:0]        stat,
  output logic              pending,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        err_op,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_data
);
  xfer_state_e       state_q, state_d;
  logic [1:0]        stat_q, stat_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;
  fail_info_t        fail_q, fail_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic              fail_en;

  logic [1:0]        sc_op;
  logic [DATA_W-1:0] sc_data;
  logic [ADDR_W-1:0] sc_addr;

  assign sc_op   = sr[1:0];
  assign sc_data = sr[DATA_W+1:2];
  assign sc_addr = sr[SR_W-1:DATA_W+2];

  always_comb begin
    state_d  = state_q;
    stat_d   = stat_q;
    wr_d     = wr_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    rdata_d  = rdata_q;
    rdata_en = 1'b0;
    fail_d   = fail_q;
    faddr_d  = faddr_q;
    fail_en  = 1'b0;
    if (tap_reset) begin
      state_d  = XS_IDLE;
      stat_d   = ST_OK;
      wr_d     = 1'b0;
      addr_d   = '0;
      wdata_d  = '0;
      rdata_d  = '0;
      rdata_en = 1'b1;
      fail_d   = '0;
      faddr_d  = '0;
      fail_en  = 1'b1;
    end else begin
      unique case (state_q)
        XS_REQ: if (req_ready) state_d = XS_RSP;
        XS_RSP: begin
          if (rsp_valid) begin
            state_d = XS_IDLE;
            if (rsp_code == ST_OK) begin
              if (!wr_q) begin
                rdata_d  = rsp_data;
                rdata_en = 1'b1;
              end
            end else if (stat_q == ST_OK) begin
              stat_d      = (rsp_code == ST_BUSY) ? ST_BUSY : ST_FAIL;
              fail_d.op   = wr_q ? OP_WRITE : OP_READ;
              fail_d.data = wdata_q;
              faddr_d     = addr_q;
              fail_en     = 1'b1;
            end
          end
        end
        default: ;
      endcase

      if (upd_ctl && sr[CLR_BIT]) begin
        stat_d = ST_OK;
      end

      if (upd_dmi && stat_q == ST_OK) begin
        if (state_q != XS_IDLE) begin
          stat_d      = ST_BUSY;
          fail_d.op   = sc_op;
          fail_d.data = sc_data;
          faddr_d     = sc_addr;
          fail_en     = 1'b1;
        end else if (sc_op == OP_READ || sc_op == OP_WRITE) begin
          state_d = XS_REQ;
          wr_d    = (sc_op == OP_WRITE);
          addr_d  = sc_addr;
          wdata_d = sc_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      stat_q  <= ST_OK;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      stat_q  <= stat_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= '0;
      faddr_q <= '0;
    end else if (fail_en) begin
      fail_q  <= fail_d;
      faddr_q <= faddr_d;
    end
  end

  assign req_valid = (state_q == XS_REQ);
  assign rsp_ready = (state_q == XS_RSP);
  assign req_write = wr_q;
  assign req_addr  = addr_q;
  assign req_data  = wdata_q;
  assign stat      = stat_q;
  assign pending   = (state_q != XS_IDLE);
  assign rdata     = rdata_q;
  assign err_op    = fail_q.op;
  assign err_addr  = faddr_q;
  assign err_data  = fail_q.data;
endmodule

// File: rtl/dtm_bridge.sv
module dtm_bridge
  import dtm_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_reset,
  input  logic              sel_dmi,
  input  logic              sel_ctl,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_data,
  input  logic [1:0]        rsp_code,
  output logic [1:0]        err_op,
  output logic [ADDR_W-1:0] err_addr,
  output logic [31:0]       err_data
);
  localparam int unsigned SR_W = ADDR_W + DATA_W + 2;

  logic [SR_W-1:0]   sr_w;
  logic [SR_W-1:0]   cap_dmi_w;
  logic [CTL_W-1:0]  cap_ctl_w;
  logic [1:0]        stat_w;
  logic [1:0]        cap_stat_w;
  logic              pending_w;
  logic [DATA_W-1:0] rdata_w;
  logic              upd_dmi_w, upd_ctl_w;

  assign upd_dmi_w = update_dr & sel_dmi;
  assign upd_ctl_w = update_dr & sel_ctl & ~sel_dmi;

  assign cap_stat_w = (stat_w != ST_OK) ? stat_w : (pending_w ? ST_BUSY : ST_OK);
  assign cap_dmi_w  = {req_addr, rdata_w, cap_stat_w};
  assign cap_ctl_w  = {20'd0, stat_w, 6'(ADDR_W), CTL_VERSION};

  dtm_scan #(.ADDR_W(ADDR_W)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .tap_reset  (tap_reset),
    .sel_dmi    (sel_dmi),
    .sel_ctl    (sel_ctl),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .tdi        (tdi),
    .cap_dmi    (cap_dmi_w),
    .cap_ctl    (cap_ctl_w),
    .sr         (sr_w),
    .tdo        (tdo)
  );

  dtm_core #(.ADDR_W(ADDR_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_reset (tap_reset),
    .upd_dmi   (upd_dmi_w),
    .upd_ctl   (upd_ctl_w),
    .sr        (sr_w),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_code  (rsp_code),
    .stat      (stat_w),
    .pending   (pending_w),
    .rdata     (rdata_w),
    .err_op    (err_op),
    .err_addr  (err_addr),
    .err_data  (err_data)
  );
endmodule

// File: rtl/dtm_bridge_chk.sv
module dtm_bridge_chk #(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tap_reset,
  input logic              update_dr,
  input logic              sel_ctl,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_data,
  input logic              rsp_ready,
  input logic [1:0]        stat,
  input logic [1:0]        err_op,
  input logic [ADDR_W-1:0] err_addr
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !tap_reset) |=> (req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_write))); // R2

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !rsp_ready); // R2

  AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    stat != 2'd1); // R3

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stat != 2'd0 && !tap_reset && !(update_dr && sel_ctl)) |=> (stat == $past(stat))); // R5

  AST_NO_REQ_WHEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> ($past(stat) == 2'd0)); // R6

  AST_FAIL_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat != 2'd0 && !tap_reset) |=> ($stable(err_op) && $stable(err_addr))); // R8

  AST_TLR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tap_reset |=> (stat == 2'd0 && !req_valid && !rsp_ready && err_op == 2'd0)); // R10
endmodule

bind dtm_bridge dtm_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tap_reset (tap_reset),
  .update_dr (update_dr),
  .sel_ctl   (sel_ctl),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_data  (req_data),
  .rsp_ready (rsp_ready),
  .stat      (stat_w),
  .err_op    (err_op),
  .err_addr  (err_addr)
);

// File: tb/sim_dtm_bridge.sv
module sim_dtm_bridge;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DW = ADDR_W + 34;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic tap_reset = 1'b0, sel_dmi = 1'b0, sel_ctl = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic req_valid, req_ready = 1'b0, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0] req_data;
  logic rsp_valid = 1'b0, rsp_ready;
  logic [31:0] rsp_data = '0;
  logic [1:0] rsp_code = '0;
  logic [1:0] err_op;
  logic [ADDR_W-1:0] err_addr;
  logic [31:0] err_data;

  int checks = 0, fails = 0, req_seen = 0;
  int lat_cfg = 2;
  logic [1:0]  code_cfg = 2'd0;
  logic [31:0] data_cfg = '0;
  bit done = 1'b0;

  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] act_q[$];
  string         tag_q[$];
  logic [ADDR_W+32:0] exp_req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dtm_bridge #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset), .sel_dmi(sel_dmi), .sel_ctl(sel_ctl),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_code(rsp_code), .err_op(err_op), .err_addr(err_addr), .err_data(err_data)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dmi_word(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                                             input logic [1:0] o);
    return {a, d, o};
  endfunction

  function automatic logic [DW-1:0] ctl_word(input logic [1:0] st);
    return DW'({20'd0, st, 6'(ADDR_W), 4'd1});
  endfunction

  // driver: expected capture into scoreboard, then scan
  task automatic scan(input string tag, input logic ctl, input logic [DW-1:0] din,
                      input logic [DW-1:0] exp_cap);
    logic [DW-1:0] cap;
    int n;
    cap = '0;
    n = ctl ? 32 : DW;
    exp_q.push_back(exp_cap);
    tag_q.push_back(tag);
    @(negedge clk);
    sel_dmi = !ctl; sel_ctl = ctl; capture_dr = 1'b1;
    @(negedge clk);
    capture_dr = 1'b0; shift_dr = 1'b1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i];
      cap[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 1'b0; update_dr = 1'b1;
    @(negedge clk);
    update_dr = 1'b0;
    act_q.push_back(cap);
  endtask

  // monitor: compare captured words
  always @(negedge clk) begin
    if (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [DW-1:0] a, e;
      string t;
      a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      check(t, 64'(a), 64'(e));
    end
  end

  // responder for the debug module side
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (req_valid) begin
        logic [ADDR_W+32:0] e;
        req_ready = 1'b1;
        req_seen++;
        if (exp_req_q.size() > 0) begin
          e = exp_req_q.pop_front();
          check("R2 request fields", 64'({req_write, req_addr, req_data}), 64'(e));
        end else begin
          check("R6 unexpected request", 64'(1), 64'(0));
        end
        @(negedge clk);
        req_ready = 1'b0;
        repeat (lat_cfg) @(negedge clk);
        rsp_valid = 1'b1; rsp_code = code_cfg; rsp_data = data_cfg;
        while (!rsp_ready) @(negedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 req_valid after reset", 64'(req_valid), 64'(0));
    check("R11 err_op after reset", 64'(err_op), 64'(0));
    check("R11 err_addr after reset", 64'(err_addr), 64'(0));

    // R9 control register fields
    scan("R9 ctl idle", 1'b1, '0, ctl_word(2'd0));

    // R1 R2 write
    exp_req_q.push_back({1'b1, 6'd5, 32'hA5A5_0001});
    scan("R1 first capture", 1'b0, dmi_word(6'd5, 32'hA5A5_0001, 2'd2), dmi_word('0, '0, 2'd0));
    repeat (20) @(negedge clk);

    // R2 read with good data
    data_cfg = 32'h1234_5678; code_cfg = 2'd0;
    exp_req_q.push_back({1'b0, 6'd9, 32'h0});
    scan("R3 after write ok", 1'b0, dmi_word(6'd9, '0, 2'd1), dmi_word(6'd5, '0, 2'd0));
    repeat (20) @(negedge clk);

    // R1 op 3 is a nop
    n0 = req_seen;
    scan("R4 read data returned", 1'b0, dmi_word(6'd1, '0, 2'd3), dmi_word(6'd9, 32'h1234_5678, 2'd0));
    repeat (20) @(negedge clk);
    check("R1 op3 issues nothing", 64'(req_seen), 64'(n0));

    // busy reply on a read
    data_cfg = 32'hDEAD_BEEF; code_cfg = 2'd3;
    exp_req_q.push_back({1'b0, 6'h11, 32'h0});
    scan("R3 before busy", 1'b0, dmi_word(6'h11, '0, 2'd1), dmi_word(6'd9, 32'h1234_5678, 2'd0));
    repeat (20) @(negedge clk);
    n0 = req_seen;
    scan("R4 busy keeps data", 1'b0, dmi_word(6'h22, 32'h7, 2'd2), dmi_word(6'h11, 32'h1234_5678, 2'd3));
    repeat (20) @(negedge clk);
    check("R6 write ignored while sticky", 64'(req_seen), 64'(n0));
    check("R8 failed op", 64'(err_op), 64'(1));
    check("R8 failed addr", 64'(err_addr), 64'(6'h11));

    // clear through control register
    scan("R9 ctl shows busy", 1'b1, DW'(32'h0001_0000), ctl_word(2'd3));
    scan("R9 ctl cleared", 1'b1, '0, ctl_word(2'd0));

    // failed reply
    code_cfg = 2'd2;
    exp_req_q.push_back({1'b0, 6'd3, 32'h0});
    scan("R3 before fail", 1'b0, dmi_word(6'd3, '0, 2'd1), dmi_word(6'h11, 32'h1234_5678, 2'd0));
    repeat (20) @(negedge clk);
    scan("R3 failed code", 1'b0, dmi_word('0, '0, 2'd0), dmi_word(6'd3, 32'h1234_5678, 2'd2));
    check("R8 failed read addr", 64'(err_addr), 64'(3));
    scan("R9 ctl shows fail", 1'b1, DW'(32'h0001_0000), ctl_word(2'd2));

    // overlap: update while outstanding, then failed reply
    lat_cfg = 120; code_cfg = 2'd2;
    exp_req_q.push_back({1'b0, 6'd4, 32'h0});
    n0 = req_seen;
    scan("R3 before overlap", 1'b0, dmi_word(6'd4, '0, 2'd1), dmi_word(6'd3, 32'h1234_5678, 2'd0));
    scan("R7 outstanding shows busy", 1'b0, dmi_word(6'h3F, 32'hCAFE, 2'd2), dmi_word(6'd4, 32'h1234_5678, 2'd3));
    check("R8 dropped op latched", 64'(err_op), 64'(2));
    check("R8 dropped addr latched", 64'(err_addr), 64'(6'h3F));
    check("R8 dropped data latched", 64'(err_data), 64'(32'hCAFE));
    repeat (200) @(negedge clk);
    check("R7 only one request", 64'(req_seen), 64'(n0 + 1));
    scan("R5 busy not overwritten", 1'b0, '0, dmi_word(6'd4, 32'h1234_5678, 2'd3));
    check("R8 first failure kept", 64'(err_addr), 64'(6'h3F));

    // Test-Logic-Reset
    @(negedge clk);
    tap_reset = 1'b1;
    @(negedge clk);
    tap_reset = 1'b0;
    check("R10 err_op cleared", 64'(err_op), 64'(0));
    check("R10 err_data cleared", 64'(err_data), 64'(0));
    scan("R10 ctl stat cleared", 1'b1, '0, ctl_word(2'd0));
    scan("R10 dmi capture cleared", 1'b0, '0, dmi_word('0, '0, 2'd0));

    repeat (5) @(negedge clk);
    check("R2 scoreboard drained", 64'(exp_q.size() + exp_req_q.size()), 64'(0));
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule